// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one double-data-rate SDRAM read or write burst, one element per clock, in the order the burst type asks for. A single-cycle start pulse captures a column address, a burst length code and a type select. From the next cycle on, the block shows one column address per cycle with a valid strobe, and it marks the final element with a last flag. The burst lives inside an aligned block whose size equals the burst length. Only the low offset bits inside that block move. The bits above the block are copied from the captured column.

Two orders are offered. The wrapping order counts the offset up from the start point and wraps at the block edge. The interleaved order forms each offset as the start offset XOR a running element index. Next to the sequencer sits a latency stage that measures the first-read-data point: a two-clock delay pulse, plus a flag that says whether a further half cycle applies. That way the whole block works on one clock edge. A start that arrives during a burst cuts it short, and the new burst begins on the next cycle.

Top module: `burst_col_seq`

## Requirements
- R1: With `ilv_i` = 0 the offset inside the block counts up by one per element from the start offset and wraps modulo the burst length (length 8, start 5 gives 5,6,7,0,1,2,3,4).
- R2: With `ilv_i` = 1 the offset of element k is the start offset XOR k (length 8, start 5 gives 5,4,7,6,1,0,3,2).
- R3: The start offset is `col_i` modulo the length (bit 0 for 2, bits 1..0 for 4, bits 2..0 for 8). Every column bit above those bits equals the captured `col_i` for the whole burst.
- R4: `blen_i` codes 1, 2 and 3 select lengths 2, 4 and 8. After the edge that samples a start, `vld_o` is high for exactly that many consecutive cycles, with the first element in the first of them.
- R5: `last_o` is high only while the final element is shown. After it, `vld_o` falls unless a new start was sampled.
- R6: A start with `blen_i` = 0 (reserved) is ignored. An idle block stays idle, a running burst carries on unchanged, and no latency pulse follows.
- R7: A valid start sampled during a burst ends that burst. The next cycle shows the first element of the new burst.
- R8: `lat_hit_o` is high for exactly one cycle, the one that ends at the second rising edge after the edge that sampled a valid start.
- R9: `lat_half_o` is high together with `lat_hit_o` exactly when `half_i` was 1 at the start. This marks the 2.5-clock latency setting. It is never high without `lat_hit_o`.
- R10: While `rst_n` is low, `vld_o`, `last_o`, `lat_hit_o` and `lat_half_o` are low. Release of the reset takes effect on a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the inputs below |
| col_i | input | COL_W | Start column address |
| blen_i | input | 2 | Length code: 0 reserved, 1 = 2, 2 = 4, 3 = 8 |
| ilv_i | input | 1 | Burst type: 0 wrapping, 1 interleaved |
| half_i | input | 1 | Latency setting: 0 = 2 clocks, 1 = 2.5 clocks |
| col_o | output | COL_W | Column address of the current element |
| vld_o | output | 1 | Element valid |
| last_o | output | 1 | Final element of the burst |
| lat_hit_o | output | 1 | First read data point reached |
| lat_half_o | output | 1 | Extra half cycle applies to this data point |

## Verification
Several properties are checked on every cycle:
- once started, a burst keeps going until its last element;
- `last_o` is never high without `vld_o`, and the block goes idle after it;
- a reserved start leaves an idle block idle;
- column bits above the largest block stay stable during a burst;
- the latency pulse lasts one cycle, and its half flag never appears on its own.

Some behaviour only the bench scenarios can show. These are the exact address order for every start offset, length and type, the exact length of each burst, truncation by a restart, and the cycle at which the latency pulse appears.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int unsigned BCS_OFS_W = 3;

  typedef enum logic [1:0] {
    BLEN_RSVD = 2'd0,
    BLEN_2    = 2'd1,
    BLEN_4    = 2'd2,
    BLEN_8    = 2'd3
  } blen_e;

  // mask of offset bits that move; also the index of the final element
  function automatic logic [BCS_OFS_W-1:0] blen_mask(blen_e b);
    logic [BCS_OFS_W-1:0] m;
    case (b)
      BLEN_2:  m = 3'b001;
      BLEN_4:  m = 3'b011;
      BLEN_8:  m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [COL_W-1:0]     col_i,
  input  blen_e                blen_i,
  input  logic                 ilv_i,
  output logic                 take_o,
  output logic                 active_o,
  output logic                 last_o,
  output logic [BCS_OFS_W-1:0] idx_o,
  output logic [COL_W-1:0]     base_o,
  output blen_e                blen_o,
  output logic                 ilv_o
);
  logic                 active_q, active_d;
  logic [BCS_OFS_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0]     base_q;
  blen_e                blen_q;
  logic                 ilv_q;
  logic                 take, at_end, step_en;

  // next-state logic
  always_comb begin
    take     = start_i && (blen_i != BLEN_RSVD);
    at_end   = active_q && (idx_q == blen_mask(blen_q));
    step_en  = take || active_q;
    active_d = active_q;
    idx_d    = idx_q;
    if (take) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (at_end) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d    = idx_q + 1'b1;
      end
    end
  end

  // sequencing state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (step_en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  // captured burst settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      blen_q <= BLEN_RSVD;
      ilv_q  <= 1'b0;
    end else if (take) begin
      base_q <= col_i;
      blen_q <= blen_i;
      ilv_q  <= ilv_i;
    end
  end

  assign take_o   = take;
  assign active_o = active_q;
  assign last_o   = at_end;
  assign idx_o    = idx_q;
  assign base_o   = base_q;
  assign blen_o   = blen_q;
  assign ilv_o    = ilv_q;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]     base_i,
  input  blen_e                blen_i,
  input  logic                 ilv_i,
  input  logic [BCS_OFS_W-1:0] idx_i,
  output logic [COL_W-1:0]     col_o
);
  logic [BCS_OFS_W-1:0] mask, st, ofs_wrap, ofs_xor, ofs;

  always_comb begin
    mask     = blen_mask(blen_i);
    st       = base_i[BCS_OFS_W-1:0];
    ofs_wrap = st + idx_i;   // wraps mod 8, masked down to the block
    ofs_xor  = st ^ idx_i;
    ofs      = ilv_i ? ofs_xor : ofs_wrap;
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < BCS_OFS_W) begin : g_low
      assign col_o[b] = mask[b] ? ofs[b] : base_i[b];
    end else begin : g_high
      assign col_o[b] = base_i[b];
    end
  end
endmodule

// File: rtl/bcs_latency.sv
module bcs_latency #(
  parameter int unsigned LAT_WHOLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic half_i,
  output logic hit_o,
  output logic half_o
);
  localparam int unsigned CNT_W = $clog2(LAT_WHOLE + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT_WHOLE - 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;
  logic             half_q;
  logic             tick_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    hit_d   = 1'b0;
    tick_en = take_i || armed_q || hit_q;
    if (take_i) begin
      armed_d = 1'b1;
      cnt_d   = CNT_LOAD;
    end else if (armed_q) begin
      if (cnt_q == CNT_W'(1)) begin
        armed_d = 1'b0;
        hit_d   = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
    end else if (tick_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      hit_q   <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_q <= 1'b0;
    else if (take_i) half_q <= half_i;
  end

  assign hit_o  = hit_q;
  assign half_o = hit_q & half_q;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W     = 10,
  parameter int unsigned LAT_WHOLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  input  logic             half_i,
  output logic [COL_W-1:0] col_o,
  output logic             vld_o,
  output logic             last_o,
  output logic             lat_hit_o,
  output logic             lat_half_o
);
  logic                 rst_sync_n;
  logic                 take, active, at_end, ilv_q;
  logic [BCS_OFS_W-1:0] idx;
  logic [COL_W-1:0]     base;
  blen_e                blen_q;

  bcs_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcs_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .col_i    (col_i),
    .blen_i   (blen_e'(blen_i)),
    .ilv_i    (ilv_i),
    .take_o   (take),
    .active_o (active),
    .last_o   (at_end),
    .idx_o    (idx),
    .base_o   (base),
    .blen_o   (blen_q),
    .ilv_o    (ilv_q)
  );

  bcs_addr_gen #(.COL_W(COL_W)) i_addr (
    .base_i (base),
    .blen_i (blen_q),
    .ilv_i  (ilv_q),
    .idx_i  (idx),
    .col_o  (col_o)
  );

  bcs_latency #(.LAT_WHOLE(LAT_WHOLE)) i_lat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .take_i (take),
    .half_i (half_i),
    .hit_o  (lat_hit_o),
    .half_o (lat_half_o)
  );

  assign vld_o  = active;
  assign last_o = at_end;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int unsigned HI_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [1:0]      blen_i,
  input logic [HI_W-1:0] col_hi,
  input logic            vld_o,
  input logic            last_o,
  input logic            lat_hit_o,
  input logic            lat_half_o
);
  // a valid start always yields an element next cycle
  assert_start_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && blen_i != 2'd0) |=> vld_o);

  // burst runs on until its final element
  assert_burst_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !last_o && !start_i) |=> vld_o);

  assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> vld_o);

  assert_idle_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !vld_o);

  assert_high_bits_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !last_o && !start_i) |=> $stable(col_hi));

  assert_reserved_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && blen_i == 2'd0 && !vld_o) |=> !vld_o);

  assert_lat_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hit_o |=> !lat_hit_o);

  assert_half_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat_half_o |-> lat_hit_o);
endmodule

bind burst_col_seq bcs_chk #(.HI_W(COL_W - 3)) i_bcs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .blen_i     (blen_i),
  .col_hi     (col_o[COL_W-1:3]),
  .vld_o      (vld_o),
  .last_o     (last_o),
  .lat_hit_o  (lat_hit_o),
  .lat_half_o (lat_half_o)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] col_i;
  logic [1:0]       blen_i;
  logic             ilv_i;
  logic             half_i;
  logic [COL_W-1:0] col_o;
  logic             vld_o, last_o, lat_hit_o, lat_half_o;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .half_i(half_i), .col_o(col_o),
    .vld_o(vld_o), .last_o(last_o), .lat_hit_o(lat_hit_o), .lat_half_o(lat_half_o)
  );

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected elements as the design shows them
  always @(negedge clk) begin
    if (mon_en && vld_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected element", longint'(col_o), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(col_o == e.col, e.req, "column", longint'(col_o), longint'(e.col));
        chk(last_o == e.last, "R5", "last flag", longint'(last_o), longint'(e.last));
      end
    end
  end

  // driver: issue a start, then load the scoreboard after the capture edge
  task automatic run_burst(input logic [COL_W-1:0] col, input int bl,
                           input bit ilv, input bit half);
    int len, s;
    len = 1 << bl;
    s   = int'(col) % len;
    @(posedge clk); #1;
    col_i = col; blen_i = 2'(bl); ilv_i = ilv; half_i = half; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    exp_q.delete();
    for (int k = 0; k < len; k++) begin
      exp_t e;
      int   ofs;
      ofs    = ilv ? (s ^ k) : ((s + k) % len);
      e.col  = COL_W'(int'(col) - s + ofs);
      e.last = (k == len - 1);
      e.req  = ilv ? "R2" : "R1";
      exp_q.push_back(e);
    end
    @(negedge clk);
    chk(lat_hit_o == 1'b0, "R8", "latency early", longint'(lat_hit_o), 0);
    @(negedge clk);
    chk(lat_hit_o == 1'b1, "R8", "latency pulse", longint'(lat_hit_o), 1);
    chk(lat_half_o == half, "R9", "half flag", longint'(lat_half_o), longint'(half));
    @(negedge clk);
    chk(lat_hit_o == 1'b0, "R8", "latency width", longint'(lat_hit_o), 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && (exp_q.size() != 0 || vld_o); i++) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "elements missing", longint'(exp_q.size()), 0);
  endtask

  task automatic reserved_start();
    @(posedge clk); #1;
    col_i = COL_W'($urandom); blen_i = 2'd0; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; col_i = '0; blen_i = 2'd1; ilv_i = 1'b0; half_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(vld_o == 1'b0, "R10", "vld in reset", longint'(vld_o), 0);
    chk(last_o == 1'b0 && lat_hit_o == 1'b0 && lat_half_o == 1'b0, "R10",
        "flags in reset", longint'({last_o, lat_hit_o, lat_half_o}), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vld_o == 1'b0, "R10", "vld after release", longint'(vld_o), 0);
    mon_en = 1'b1;

    // R1 R2 R3 R4: every start offset, every length, both types
    for (int bl = 1; bl <= 3; bl++) begin
      for (int t = 0; t < 2; t++) begin
        for (int s = 0; s < (1 << bl); s++) begin
          logic [COL_W-1:0] c;
          c = COL_W'($urandom);
          c = (c & ~COL_W'((1 << bl) - 1)) | COL_W'(s);
          run_burst(c, bl, t[0], s[0]);
          wait_idle();
        end
      end
    end

    // R6: reserved start while idle
    reserved_start();
    repeat (3) begin
      @(negedge clk);
      chk(vld_o == 1'b0 && lat_hit_o == 1'b0, "R6", "reserved idle",
          longint'({vld_o, lat_hit_o}), 0);
    end

    // R6: reserved start during a burst leaves it running
    run_burst(10'h2f5, 3, 1'b0, 1'b0);
    reserved_start();
    @(negedge clk);
    chk(lat_hit_o == 1'b0, "R6", "reserved latency", longint'(lat_hit_o), 0);
    wait_idle();

    // R7: restart cuts a running burst
    run_burst(10'h1a3, 3, 1'b1, 1'b1);
    run_burst(10'h056, 2, 1'b0, 1'b0);
    wait_idle();
    run_burst(10'h3fd, 3, 1'b0, 1'b1);
    run_burst(10'h10e, 3, 1'b1, 1'b0);
    wait_idle();
    chk(vld_o == 1'b0, "R7", "idle after restart", longint'(vld_o), 0);

    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end
endmodule